// File: doc/BRIEF.md
# Multiplexed Byte-Lane Host Register Port

This block is the slave end of a narrow host bus on which one 8-bit lane carries first a register address and then a data byte. The host selects the chip with an active-low chip select and uses a separate phase line: when the phase line is high, a write strobe loads the byte on the lane into an address latch. When it is low, a read or write strobe moves one data byte to or from the register that the latch points at. The block decodes the latched address into a one-hot select for the register slots that live outside it, and issues a one-cycle write or read strobe to them. It returns read data on the lane and tells the host when the access has completed through an active-low ready line.

Two slots are held inside the block. The interrupt control register at offset 0x00 holds two enable bits and a pending flag, and drives an active-low interrupt line. The host clears the pending flag by reading this register. Offset 0x0F returns a fixed revision byte. Slow registers outside the block can hold the access open with a busy input, and ready stays deasserted until they drop it. The bus inputs are assumed to be synchronous to the block clock.

Top module: `mux_hostbus_slave`

## Requirements
- R1: A write strobe while chip select is low and the phase line is high loads the lane byte into the address latch and produces no register strobe. The latched address is used unchanged by every following data cycle until the next address cycle.
- R2: A data-phase write to an external slot (0x01, 0x04 to 0x0A, 0x0C, 0x0D) raises `reg_wr_stb` for exactly one cycle. During that cycle `reg_sel` is the one-hot code of the latched address (bit n for offset n) and `reg_wdata` is the byte the host drove.
- R3: A data-phase read of an external slot raises `reg_rd_stb` for one cycle. It then presents that slot's byte from `reg_rdata` (slot n at bits 8n+7..8n) on `hb_data_out`, with `hb_data_oe` high, while `hb_rdy_n` is low. `hb_data_oe` is never high unless `hb_rdy_n` is low.
- R4: `hb_rdy_n` goes low one cycle after the strobe cycle when `reg_busy` is low, and stays high for as long as `reg_busy` is held high during an external access. It returns high in the cycle after the host releases its strobe.
- R5: Offsets 0x02, 0x03, 0x0B, 0x0E and any offset of 0x10 or above are unmapped. A read of one of them returns 0x00, and a write to one of them raises no strobe and no select.
- R6: A read of offset 0x0F returns the REVISION parameter. A write to offset 0x0F raises no strobe and leaves the value read back unchanged.
- R7: The interrupt control register at 0x00 reads as enable A at bit 6, enable B at bit 2 and pending at bit 0, with all other bits 0. Writing 0x44 sets both enables. A write that leaves either enable clear also clears pending.
- R8: An `irq_event` pulse sets pending only while both enables are set, and `hb_irq_n` is low exactly while pending is set.
- R9: A read of offset 0x00 clears pending once the read data is captured, so `hb_irq_n` is high after that read. If `irq_event` is high in the capture cycle, pending stays set.
- R10: After reset `hb_rdy_n` and `hb_irq_n` are high, `hb_data_oe` is low, no select or strobe is active, and the interrupt control register reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_ale | input | 1 | Phase line: 1 address cycle, 0 data cycle |
| hb_wr_n | input | 1 | Host write strobe, active low |
| hb_rd_n | input | 1 | Host read strobe, active low |
| hb_data_in | input | 8 | Byte lane from the host |
| hb_data_out | output | 8 | Byte lane to the host |
| hb_data_oe | output | 1 | Lane drive enable toward the host |
| hb_rdy_n | output | 1 | Access complete, active low |
| hb_irq_n | output | 1 | Interrupt request, active low |
| reg_sel | output | 16 | One-hot select of the external slot at the latched address |
| reg_wr_stb | output | 1 | One-cycle write strobe to the selected slot |
| reg_rd_stb | output | 1 | One-cycle read strobe to the selected slot |
| reg_wdata | output | 8 | Write byte for the selected slot |
| reg_rdata | input | 128 | Read bytes of all slots, slot n at bits 8n+7..8n |
| reg_busy | input | 1 | Selected external slot has not finished its access |
| irq_event | input | 1 | Interrupt source event |

## Verification
A corrupted address latch shows in the very next data cycle as the wrong `reg_sel` bit or the wrong read byte. The bench therefore runs several data cycles after one address cycle and compares the select seen in each. A phase machine that is stuck or skips its wait state shows as a ready count that differs from the busy hold by at least one cycle, or as a ready line that never returns high. The bench counts both for every transfer. A wrong interrupt enable or a wrong acknowledge shows on `hb_irq_n` within one cycle of the event or of the capturing read, and the bench samples the line right after each of these.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ACC  = 2'd1,
      PH_DONE = 2'd2
   } ph_state_t;

   localparam int IC_EN_A_BIT = 6;
   localparam int IC_EN_B_BIT = 2;
   localparam int IC_PEND_BIT = 0;
endpackage

// File: rtl/hbus_phase.sv
module hbus_phase
   import hbus_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n,
   input  logic ale,
   input  logic wr_n,
   input  logic rd_n,
   input  logic busy,
   output logic addr_load,
   output logic null_rd,
   output logic acc_wr_q,
   output logic acc_rd_q,
   output logic capture,
   output logic is_rd_q,
   output logic done
);
   ph_state_t state_q;
   logic wr_act, rd_act, wr_act_q, rd_act_q;
   logic start_wr, start_rd;

   assign wr_act   = !cs_n && !wr_n;
   assign rd_act   = !cs_n && !rd_n;
   assign start_wr = (state_q == PH_IDLE) && wr_act && !wr_act_q;
   assign start_rd = (state_q == PH_IDLE) && !start_wr && rd_act && !rd_act_q;

   assign addr_load = start_wr && ale;
   assign null_rd   = start_rd && ale;
   assign capture   = (state_q == PH_ACC) && !busy;
   assign done      = (state_q == PH_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= PH_IDLE;
         wr_act_q <= 1'b0;
         rd_act_q <= 1'b0;
         acc_wr_q <= 1'b0;
         acc_rd_q <= 1'b0;
         is_rd_q  <= 1'b0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         acc_wr_q <= start_wr && !ale;
         acc_rd_q <= start_rd && !ale;
         unique case (state_q)
            PH_IDLE: begin
               if (start_wr) begin
                  is_rd_q <= 1'b0;
                  state_q <= ale ? PH_DONE : PH_ACC;
               end else if (start_rd) begin
                  is_rd_q <= 1'b1;
                  state_q <= ale ? PH_DONE : PH_ACC;
               end
            end
            PH_ACC: begin
               if (!busy) state_q <= PH_DONE;
            end
            PH_DONE: begin
               if (!wr_act && !rd_act) state_q <= PH_IDLE;
            end
            default: state_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/hbus_decode.sv
module hbus_decode #(
   parameter int          DATA_W   = 8,
   parameter int          SLOT_CNT = 16,
   parameter logic [15:0] EXT_MAP  = 16'h37F2,
   parameter int          INT_OFS  = 0,
   parameter int          REV_OFS  = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_load,
   input  logic [DATA_W-1:0] addr_in,
   output logic [SLOT_CNT-1:0] sel,
   output logic              ext_hit,
   output logic              int_hit,
   output logic              rev_hit
);
   logic [DATA_W-1:0] addr_q;
   logic              in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         addr_q <= '0;
      else if (addr_load) addr_q <= addr_in;
   end

   assign in_range = ({1'b0, addr_q} < (DATA_W+1)'(SLOT_CNT));

   for (genvar gi = 0; gi < SLOT_CNT; gi++) begin : g_slot
      if (EXT_MAP[gi]) begin : g_ext
         assign sel[gi] = in_range && (addr_q == DATA_W'(gi));
      end else begin : g_none
         assign sel[gi] = 1'b0;
      end
   end

   assign ext_hit = |sel;
   assign int_hit = in_range && (addr_q == DATA_W'(INT_OFS));
   assign rev_hit = in_range && (addr_q == DATA_W'(REV_OFS));
endmodule

// File: rtl/hbus_irq.sv
module hbus_irq
   import hbus_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack,
   input  logic              event_in,
   output logic [DATA_W-1:0] ctrl_byte,
   output logic              irq_n
);
   logic en_a_q, en_b_q, pend_q;
   logic en_a_nx, en_b_nx;

   assign en_a_nx = wr_en ? wdata[IC_EN_A_BIT] : en_a_q;
   assign en_b_nx = wr_en ? wdata[IC_EN_B_BIT] : en_b_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_a_q <= 1'b0;
         en_b_q <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         en_a_q <= en_a_nx;
         en_b_q <= en_b_nx;
         if (!(en_a_nx && en_b_nx))       pend_q <= 1'b0;
         else if (event_in && en_a_q && en_b_q) pend_q <= 1'b1;
         else if (ack)                    pend_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_byte              = '0;
      ctrl_byte[IC_EN_A_BIT] = en_a_q;
      ctrl_byte[IC_EN_B_BIT] = en_b_q;
      ctrl_byte[IC_PEND_BIT] = pend_q;
   end

   assign irq_n = !pend_q;
endmodule

// File: rtl/mux_hostbus_slave.sv
module mux_hostbus_slave #(
   parameter int          DATA_W   = 8,
   parameter int          SLOT_CNT = 16,
   parameter logic [15:0] EXT_MAP  = 16'h37F2,
   parameter logic [7:0]  REVISION = 8'hA3,
   parameter int          INT_OFS  = 0,
   parameter int          REV_OFS  = 15
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     hb_cs_n,
   input  logic                     hb_ale,
   input  logic                     hb_wr_n,
   input  logic                     hb_rd_n,
   input  logic [DATA_W-1:0]        hb_data_in,
   output logic [DATA_W-1:0]        hb_data_out,
   output logic                     hb_data_oe,
   output logic                     hb_rdy_n,
   output logic                     hb_irq_n,
   output logic [SLOT_CNT-1:0]      reg_sel,
   output logic                     reg_wr_stb,
   output logic                     reg_rd_stb,
   output logic [DATA_W-1:0]        reg_wdata,
   input  logic [SLOT_CNT*DATA_W-1:0] reg_rdata,
   input  logic                     reg_busy,
   input  logic                     irq_event
);
   localparam int RDATA_W = SLOT_CNT * DATA_W;

   initial begin
      assert (DATA_W == 8) else $error("byte lane must be 8 bits");
      assert (SLOT_CNT >= 16 && SLOT_CNT <= 16) else $error("slot count must match the 16-bit map");
      assert (INT_OFS < SLOT_CNT && REV_OFS < SLOT_CNT) else $error("internal offsets out of range");
      assert (!EXT_MAP[INT_OFS] && !EXT_MAP[REV_OFS]) else $error("internal offsets marked external");
   end

   logic addr_load, null_rd, acc_wr_q, acc_rd_q, capture, is_rd_q, done;
   logic ext_hit, int_hit, rev_hit, busy_eff;
   logic [DATA_W-1:0] wdata_q, rd_mux, dout_q, ic_byte;
   logic [SLOT_CNT-1:0] sel;

   assign busy_eff = reg_busy && ext_hit;

   hbus_phase u_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_n      (hb_cs_n),
      .ale       (hb_ale),
      .wr_n      (hb_wr_n),
      .rd_n      (hb_rd_n),
      .busy      (busy_eff),
      .addr_load (addr_load),
      .null_rd   (null_rd),
      .acc_wr_q  (acc_wr_q),
      .acc_rd_q  (acc_rd_q),
      .capture   (capture),
      .is_rd_q   (is_rd_q),
      .done      (done)
   );

   hbus_decode #(
      .DATA_W   (DATA_W),
      .SLOT_CNT (SLOT_CNT),
      .EXT_MAP  (EXT_MAP),
      .INT_OFS  (INT_OFS),
      .REV_OFS  (REV_OFS)
   ) u_decode (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_load (addr_load),
      .addr_in   (hb_data_in),
      .sel       (sel),
      .ext_hit   (ext_hit),
      .int_hit   (int_hit),
      .rev_hit   (rev_hit)
   );

   hbus_irq #(
      .DATA_W (DATA_W)
   ) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (acc_wr_q && int_hit),
      .wdata     (wdata_q),
      .ack       (capture && is_rd_q && int_hit),
      .event_in  (irq_event),
      .ctrl_byte (ic_byte),
      .irq_n     (hb_irq_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wdata_q <= '0;
      else if (!hb_cs_n && !hb_wr_n && !hb_ale && !done && !acc_wr_q) wdata_q <= hb_data_in;
   end

   always_comb begin
      rd_mux = '0;
      if (int_hit)      rd_mux = ic_byte;
      else if (rev_hit) rd_mux = REVISION;
      else begin
         for (int i = 0; i < SLOT_CNT; i++) begin
            if (sel[i]) rd_mux = reg_rdata[i*DATA_W +: DATA_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   dout_q <= '0;
      else if (null_rd)             dout_q <= '0;
      else if (capture && is_rd_q)  dout_q <= rd_mux;
   end

   assign reg_sel     = sel;
   assign reg_wr_stb  = acc_wr_q && ext_hit;
   assign reg_rd_stb  = acc_rd_q && ext_hit;
   assign reg_wdata   = wdata_q;
   assign hb_data_out = dout_q;
   assign hb_data_oe  = done && is_rd_q;
   assign hb_rdy_n    = !done;

   logic unused_w;
   assign unused_w = ^{RDATA_W[0]};
endmodule

// File: rtl/hbus_chk.sv
module hbus_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        hb_rdy_n,
   input logic        hb_data_oe,
   input logic        hb_irq_n,
   input logic [15:0] reg_sel,
   input logic        reg_wr_stb,
   input logic        reg_rd_stb,
   input logic        reg_busy,
   input logic        irq_event
);
   // R2
   wr_stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_stb |=> !reg_wr_stb);

   // R2
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(reg_sel));

   // R5
   stb_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_stb || reg_rd_stb) |-> (reg_sel != 16'h0));

   // R4
   busy_holds_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((reg_rd_stb || reg_wr_stb) && reg_busy) |=> hb_rdy_n);

   // R3
   oe_only_when_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hb_data_oe |-> !hb_rdy_n);

   // R8
   irq_from_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hb_irq_n) |-> $past(irq_event));
endmodule

bind mux_hostbus_slave hbus_chk u_hbus_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hb_rdy_n   (hb_rdy_n),
   .hb_data_oe (hb_data_oe),
   .hb_irq_n   (hb_irq_n),
   .reg_sel    (reg_sel),
   .reg_wr_stb (reg_wr_stb),
   .reg_rd_stb (reg_rd_stb),
   .reg_busy   (reg_busy),
   .irq_event  (irq_event)
);

// File: tb/mux_hostbus_slave_bench.sv
module mux_hostbus_slave_bench;
   localparam logic [7:0] REV = 8'hA3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hb_cs_n = 1'b1, hb_ale = 1'b0, hb_wr_n = 1'b1, hb_rd_n = 1'b1;
   logic [7:0] hb_data_in = 8'h00;
   logic [7:0] hb_data_out;
   logic hb_data_oe, hb_rdy_n, hb_irq_n;
   logic [15:0] reg_sel;
   logic reg_wr_stb, reg_rd_stb;
   logic [7:0] reg_wdata;
   logic [127:0] reg_rdata;
   logic reg_busy = 1'b0;
   logic irq_event = 1'b0;

   int n_vec = 0;
   int n_bad = 0;
   int cyc = 0;

   // last transfer observations
   logic [7:0]  t_dout;
   logic        t_oe;
   int          t_nwr, t_nrd, t_wait;
   logic [15:0] t_sel;
   logic [7:0]  t_wdata;
   logic        t_rdy_after;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 16; i++) reg_rdata[i*8 +: 8] = 8'(i * 17 + 1);
   end

   mux_hostbus_slave #(.REVISION(REV)) u_mux_hostbus_slave (
      .clk(clk), .rst_n(rst_n), .hb_cs_n(hb_cs_n), .hb_ale(hb_ale),
      .hb_wr_n(hb_wr_n), .hb_rd_n(hb_rd_n), .hb_data_in(hb_data_in),
      .hb_data_out(hb_data_out), .hb_data_oe(hb_data_oe), .hb_rdy_n(hb_rdy_n),
      .hb_irq_n(hb_irq_n), .reg_sel(reg_sel), .reg_wr_stb(reg_wr_stb),
      .reg_rd_stb(reg_rd_stb), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .reg_busy(reg_busy), .irq_event(irq_event)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
         end
      end
   end

   task automatic xfer(input logic ale, input logic wr, input logic [7:0] din, input int busy_cyc);
      t_nwr = 0; t_nrd = 0; t_wait = 0; t_sel = '0; t_wdata = '0;
      t_dout = '0; t_oe = 1'b0;
      @(negedge clk);
      hb_cs_n = 1'b0; hb_ale = ale; hb_data_in = din;
      hb_wr_n = !wr; hb_rd_n = wr;
      reg_busy = (busy_cyc > 0);
      for (int k = 0; k < 60; k++) begin
         @(negedge clk);
         if (reg_wr_stb) begin t_nwr++; t_wdata = reg_wdata; end
         if (reg_rd_stb) t_nrd++;
         t_sel |= reg_sel;
         if (!hb_rdy_n) break;
         t_wait++;
         if (t_wait >= busy_cyc) reg_busy = 1'b0;
      end
      t_dout = hb_data_out;
      t_oe = hb_data_oe;
      hb_cs_n = 1'b1; hb_wr_n = 1'b1; hb_rd_n = 1'b1; hb_ale = 1'b0;
      reg_busy = 1'b0;
      @(negedge clk);
      t_rdy_after = hb_rdy_n;
   endtask

   task automatic set_addr(input logic [7:0] a);
      xfer(1'b1, 1'b1, a, 0);
      chk(t_nwr == 0 && t_nrd == 0, "R1 addr cycle strobe", t_nwr + t_nrd, 0);
   endtask

   task automatic test_reset();
      chk(hb_rdy_n == 1'b1, "R10 rdy_n", hb_rdy_n, 1);
      chk(hb_irq_n == 1'b1, "R10 irq_n", hb_irq_n, 1);
      chk(hb_data_oe == 1'b0, "R10 oe", hb_data_oe, 0);
      chk(reg_sel == 16'h0 && !reg_wr_stb && !reg_rd_stb, "R10 sel/stb", reg_sel, 0);
      set_addr(8'h00);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h00, "R10 int ctrl reset value", t_dout, 0);
   endtask

   task automatic test_latch_write();
      set_addr(8'h06);
      xfer(1'b0, 1'b1, 8'h5A, 0);
      chk(t_nwr == 1, "R2 one write strobe", t_nwr, 1);
      chk(t_sel == 16'h0040, "R2 select slot 6", t_sel, 16'h0040);
      chk(t_wdata == 8'h5A, "R2 write data", t_wdata, 8'h5A);
      chk(t_wait == 1, "R4 ready latency no busy", t_wait, 1);
      chk(t_rdy_after == 1'b1, "R4 ready released", t_rdy_after, 1);
      xfer(1'b0, 1'b1, 8'hC3, 0);
      chk(t_sel == 16'h0040 && t_wdata == 8'hC3, "R1 address held over 2nd data cycle", t_sel, 16'h0040);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h67 && t_nrd == 1, "R1 address held over 3rd data cycle", t_dout, 8'h67);
   endtask

   task automatic test_reads();
      set_addr(8'h07);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h78, "R3 read slot 7", t_dout, 8'h78);
      chk(t_oe == 1'b1, "R3 oe during read", t_oe, 1);
      chk(t_sel == 16'h0080 && t_nrd == 1, "R3 read strobe/select", t_sel, 16'h0080);
      set_addr(8'h0D);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'hDE, "R3 read slot 13", t_dout, 8'hDE);
      xfer(1'b0, 1'b1, 8'h11, 0);
      chk(t_oe == 1'b0, "R3 no oe on write", t_oe, 0);
   endtask

   task automatic test_busy();
      set_addr(8'h04);
      xfer(1'b0, 1'b0, 8'h00, 4);
      chk(t_wait == 4, "R4 ready held by busy (read)", t_wait, 4);
      chk(t_dout == 8'h45, "R4 data after busy", t_dout, 8'h45);
      xfer(1'b0, 1'b1, 8'h22, 7);
      chk(t_wait == 7, "R4 ready held by busy (write)", t_wait, 7);
      chk(t_rdy_after == 1'b1, "R4 ready released after busy", t_rdy_after, 1);
   endtask

   task automatic test_unmapped();
      set_addr(8'h03);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h00 && t_nrd == 0, "R5 read 0x03", t_dout, 0);
      set_addr(8'h0B);
      xfer(1'b0, 1'b1, 8'hFF, 0);
      chk(t_nwr == 0 && t_sel == 16'h0, "R5 write 0x0B no strobe", t_sel, 0);
      set_addr(8'h31);
      xfer(1'b0, 1'b0, 8'h00, 3);
      chk(t_dout == 8'h00 && t_sel == 16'h0, "R5 read 0x31", t_dout, 0);
      chk(t_wait == 1, "R5 busy ignored when unmapped", t_wait, 1);
   endtask

   task automatic test_revision();
      set_addr(8'h0F);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == REV, "R6 revision read", t_dout, REV);
      xfer(1'b0, 1'b1, 8'h00, 0);
      chk(t_nwr == 0 && t_sel == 16'h0, "R6 revision write no strobe", t_nwr, 0);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == REV, "R6 revision unchanged", t_dout, REV);
   endtask

   task automatic pulse_event();
      @(negedge clk);
      irq_event = 1'b1;
      @(negedge clk);
      irq_event = 1'b0;
      @(negedge clk);
   endtask

   task automatic test_irq();
      pulse_event();
      chk(hb_irq_n == 1'b1, "R8 event while disabled", hb_irq_n, 1);
      set_addr(8'h00);
      xfer(1'b0, 1'b1, 8'h44, 0);
      chk(t_nwr == 0, "R7 int ctrl write internal", t_nwr, 0);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h44, "R7 enables read back", t_dout, 8'h44);
      chk(hb_irq_n == 1'b1, "R8 no irq without event", hb_irq_n, 1);
      pulse_event();
      chk(hb_irq_n == 1'b0, "R8 irq asserted", hb_irq_n, 0);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h45, "R7 pending bit read", t_dout, 8'h45);
      chk(hb_irq_n == 1'b1, "R9 read acknowledges", hb_irq_n, 1);
      // event held across the acknowledging read
      @(negedge clk);
      irq_event = 1'b1;
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(hb_irq_n == 1'b0, "R9 event wins over ack", hb_irq_n, 0);
      irq_event = 1'b0;
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h45 && hb_irq_n == 1'b1, "R9 second read clears", t_dout, 8'h45);
      pulse_event();
      xfer(1'b0, 1'b1, 8'h04, 0);
      chk(hb_irq_n == 1'b1, "R7 partial enable clears pending", hb_irq_n, 1);
      xfer(1'b0, 1'b0, 8'h00, 0);
      chk(t_dout == 8'h04, "R7 partial enable read", t_dout, 8'h04);
      pulse_event();
      chk(hb_irq_n == 1'b1, "R8 one enable not enough", hb_irq_n, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_latch_write();
      test_reads();
      test_busy();
      test_unmapped();
      test_revision();
      test_irq();
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule